// File: doc/BRIEF.md
# Interrupt Take Sequencer

This block sits next to a processor core and decides on which cycle a non-maskable interrupt (NMI) or a maskable interrupt (IRQ) is taken. It also decides when a wait-for-interrupt halt ends. The core reports each bus cycle with a strobe. It marks its instruction boundaries and the start of a halt. It supplies the interrupt-disable flag, and it raises a lock input on any cycle in which a pending DMA transfer was serviced.

An NMI request does not work on an edge. The request loads a short down-counter, and the NMI becomes pending only when that counter expires. IRQ sources are sampled once per cycle. A DMA cycle holds back an expiring NMI by one cycle and blanks the IRQ sample for that cycle. The block also tells the core when its next idle cycle must become a dummy read at the program counter, because an interrupt is about to be entered.

Top module: `int_take_seq`

## Requirements
- R1: A high `nmi_req` loads the NMI counter with `nmi_delay`. The load takes priority over counting in the same cycle, and a load of 0 cancels the NMI in flight. On each other cycle with `cyc_en` high, a nonzero counter above 1 drops by one. With `cyc_en` low, the counter holds.
- R2: On a cycle with `cyc_en` high and no `nmi_req`, a counter of 1 becomes 0 if `dma_lock` is low, and the NMI is pending from the next cycle on.
- R3: If `dma_lock` is high in that expiry cycle, the counter stays at 1 and no NMI becomes pending.
- R4: On each cycle with `cyc_en` high, the IRQ sample is registered as true when any bit of `irq_src` is set and `irq_mask` is low. It holds while `cyc_en` is low.
- R5: A cycle with `cyc_en` and `dma_lock` both high registers a false IRQ sample, whatever the sources are.
- R6: An interrupt check happens when `boundary` is high while the core is not halted, or in a halt-exit cycle. In that same cycle, a check raises `take_nmi` if an NMI is pending. Otherwise it raises `take_irq` if the IRQ sample is true. Taking the NMI clears its pending state. The two strobes are never high together.
- R7: `halt_enter` while running halts the core and clears the wake flag, and it is ignored while already halted. The wake flag is set by an NMI expiry (R2), or by a cycle with `cyc_en` high, some `irq_src` bit set and `dma_lock` low. A wake event in the `halt_enter` cycle still counts.
- R8: A halted cycle with `cyc_en` high raises `wait_done` if the wake flag was already set before that cycle. The core then runs from the next cycle, and `boundary` has no effect while halted.
- R9: An IRQ source wakes a halt even with `irq_mask` high. The exit then raises neither take strobe unless an NMI is pending.
- R10: `dummy_rd` is high whenever the NMI counter equals 1, an NMI is pending, the IRQ sample is true, or (`irq_mask` low and any `irq_src` bit set).
- R11: Reset clears the NMI counter, the pending NMI, the IRQ sample, the halt state and the wake flag. With all inputs low, every output is low in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One processor bus cycle completes on this clock |
| nmi_req | input | 1 | Load the NMI counter |
| nmi_delay | input | DLY_W | Value loaded on a request (normally 1 or 2) |
| irq_src | input | SRC_W | IRQ source bits |
| irq_mask | input | 1 | Core interrupt-disable flag |
| dma_lock | input | 1 | A DMA transfer was serviced this cycle |
| boundary | input | 1 | Instruction boundary, interrupt check point |
| halt_enter | input | 1 | Core starts a wait-for-interrupt halt |
| take_nmi | output | 1 | Enter the NMI now |
| take_irq | output | 1 | Enter the IRQ now |
| wait_done | output | 1 | Halt ends in this cycle |
| dummy_rd | output | 1 | Turn the idle cycle into a read at the program counter |

## Verification
The bench uses the default widths: a 2-bit delay field and 4 IRQ source bits. With these widths every delay value can be driven, including the cancelling 0 and the largest value, 3. With four source bits, the bench can test a single source, several sources and an empty mask. Directed cases come first: a lock held over repeated expiry cycles, a stalled cycle strobe, an NMI and an IRQ meeting at the same boundary, and halts ended by each kind of wake. A long random phase then mixes requests, locks and halts, so that loads land on expiry cycles and wake events land on halt entries.

// File: rtl/int_take_pkg.sv
package int_take_pkg;
    typedef enum logic {
        CORE_RUN  = 1'b0,
        CORE_HALT = 1'b1
    } core_mode_e;
endpackage

// File: rtl/int_nmi_timer.sv
module int_nmi_timer #(
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             req,
    input  logic [DLY_W-1:0] req_dly,
    input  logic             lock,
    input  logic             take,
    output logic             cnt_one,
    output logic             pend,
    output logic             fire
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             pend;
    } nmi_st_t;

    nmi_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = cyc_en && !req && (st_q.cnt == ONE) && !lock;
        if (req) begin
            st_d.cnt = req_dly;
        end else if (cyc_en && (st_q.cnt != '0)) begin
            if (st_q.cnt == ONE)
                st_d.cnt = lock ? ONE : '0;
            else
                st_d.cnt = st_q.cnt - ONE;
        end
        st_d.pend = fire | (st_q.pend & ~take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_one = (st_q.cnt == ONE);
    assign pend    = st_q.pend;

    assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !req && st_q.cnt == ONE && lock) |=> (st_q.cnt == ONE));

    assert_pend_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> ($past(st_q.cnt) == ONE && !$past(lock)));

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !req && st_q.cnt > ONE) |=> (st_q.cnt == $past(st_q.cnt) - ONE));
endmodule

// File: rtl/int_irq_sampler.sv
module int_irq_sampler #(
    parameter int SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic [SRC_W-1:0] src,
    input  logic             mask,
    input  logic             lock,
    output logic             smp,
    output logic             wake
);
    typedef struct packed {
        logic smp;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    any_src;

    always_comb begin
        any_src = |src;
        st_d    = st_q;
        if (cyc_en)
            st_d.smp = any_src && !mask && !lock;
        wake = cyc_en && any_src && !lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp = st_q.smp;

    assert_lock_blanks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && lock) |=> !st_q.smp);

    assert_mask_blanks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && mask) |=> !st_q.smp);
endmodule

// File: rtl/int_halt_ctrl.sv
module int_halt_ctrl
    import int_take_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic enter,
    input  logic wake,
    output logic halted,
    output logic done
);
    typedef struct packed {
        core_mode_e mode;
        logic       woke;
    } halt_st_t;

    halt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = (st_q.mode == CORE_HALT) && cyc_en && st_q.woke;
        if (st_q.mode == CORE_RUN) begin
            if (enter) begin
                st_d.mode = CORE_HALT;
                st_d.woke = wake;
            end else begin
                st_d.woke = st_q.woke | wake;
            end
        end else begin
            st_d.woke = st_q.woke | wake;
            if (done) st_d.mode = CORE_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: CORE_RUN, woke: 1'b0};
        else        st_q <= st_d;
    end

    assign halted = (st_q.mode == CORE_HALT);

    assert_no_early_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CORE_HALT && !st_q.woke) |=> (st_q.mode == CORE_HALT));

    assert_enter_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CORE_RUN && enter) |=> (st_q.mode == CORE_HALT));
endmodule

// File: rtl/int_take_seq.sv
module int_take_seq #(
    parameter int DLY_W = 2,
    parameter int SRC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             nmi_req,
    input  logic [DLY_W-1:0] nmi_delay,
    input  logic [SRC_W-1:0] irq_src,
    input  logic             irq_mask,
    input  logic             dma_lock,
    input  logic             boundary,
    input  logic             halt_enter,
    output logic             take_nmi,
    output logic             take_irq,
    output logic             wait_done,
    output logic             dummy_rd
);
    logic nmi_one, nmi_pend, nmi_fire;
    logic irq_smp, irq_wake;
    logic halted, check;

    int_nmi_timer #(.DLY_W(DLY_W)) u_nmi (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .req(nmi_req),
        .req_dly(nmi_delay), .lock(dma_lock), .take(take_nmi),
        .cnt_one(nmi_one), .pend(nmi_pend), .fire(nmi_fire)
    );

    int_irq_sampler #(.SRC_W(SRC_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .src(irq_src),
        .mask(irq_mask), .lock(dma_lock), .smp(irq_smp), .wake(irq_wake)
    );

    int_halt_ctrl u_halt (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .enter(halt_enter),
        .wake(nmi_fire | irq_wake), .halted(halted), .done(wait_done)
    );

    always_comb begin
        check    = (boundary && !halted) || wait_done;
        take_nmi = check && nmi_pend;
        take_irq = check && !nmi_pend && irq_smp;
        dummy_rd = nmi_one || nmi_pend || irq_smp || (!irq_mask && (|irq_src));
    end

    assert_one_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_nmi, take_irq}));

    assert_take_preread_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nmi || take_irq) |-> dummy_rd);
endmodule

// File: tb/int_take_seq_test.sv
module int_take_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DLY_W = 2;
    localparam int SRC_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_en = 1'b0, nmi_req = 1'b0, irq_mask = 1'b0, dma_lock = 1'b0;
    logic boundary = 1'b0, halt_enter = 1'b0;
    logic [DLY_W-1:0] nmi_delay = '0;
    logic [SRC_W-1:0] irq_src = '0;
    logic take_nmi, take_irq, wait_done, dummy_rd;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int m_cnt = 0;
    bit m_pend = 0, m_smp = 0, m_halt = 0, m_woke = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_take_seq #(.DLY_W(DLY_W), .SRC_W(SRC_W)) uut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .nmi_req(nmi_req),
        .nmi_delay(nmi_delay), .irq_src(irq_src), .irq_mask(irq_mask),
        .dma_lock(dma_lock), .boundary(boundary), .halt_enter(halt_enter),
        .take_nmi(take_nmi), .take_irq(take_irq), .wait_done(wait_done),
        .dummy_rd(dummy_rd)
    );

    task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: drive, compare at the falling edge, then advance the model
    task automatic step(input bit c, input bit r, input int d, input int s,
                        input bit mk, input bit lk, input bit b, input bit h);
        bit e_done, e_chk, e_tn, e_ti, e_dr, fire, wake;
        cyc_en = c; nmi_req = r; nmi_delay = d[DLY_W-1:0]; irq_src = s[SRC_W-1:0];
        irq_mask = mk; dma_lock = lk; boundary = b; halt_enter = h;
        @(negedge clk);
        e_done = m_halt && c && m_woke;
        e_chk  = (b && !m_halt) || e_done;
        e_tn   = e_chk && m_pend;
        e_ti   = e_chk && !m_pend && m_smp;
        e_dr   = (m_cnt == 1) || m_pend || m_smp || (!mk && (s % (1 << SRC_W)) != 0);
        check_bit("R6", "take_nmi", take_nmi, e_tn);
        check_bit("R9", "take_irq", take_irq, e_ti);
        check_bit("R8", "wait_done", wait_done, e_done);
        check_bit("R10", "dummy_rd", dummy_rd, e_dr);
        s = s % (1 << SRC_W);
        fire = c && !r && (m_cnt == 1) && !lk;
        wake = fire || (c && s != 0 && !lk);
        @(posedge clk);
        if (r) m_cnt = d % (1 << DLY_W);
        else if (c && m_cnt != 0) m_cnt = (m_cnt == 1) ? (lk ? 1 : 0) : m_cnt - 1;
        m_pend = fire || (m_pend && !e_tn);
        if (c) m_smp = !lk && s != 0 && !mk;
        if (!m_halt) begin
            if (h) begin m_halt = 1; m_woke = wake; end
            else m_woke = m_woke || wake;
        end else begin
            m_woke = m_woke || wake;
            if (e_done) m_halt = 0;
        end
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset state, all inputs low
        #(CLK_PERIOD * 2 + 2);
        check_bit("R11", "take_nmi", take_nmi, 1'b0);
        check_bit("R11", "take_irq", take_irq, 1'b0);
        check_bit("R11", "wait_done", wait_done, 1'b0);
        check_bit("R11", "dummy_rd", dummy_rd, 1'b0);
        @(posedge clk); rst_n = 1'b1; #1;
        idle(2);

        // R1, R2: delay 2, expiry, take at boundary
        step(1, 1, 2, 0, 0, 0, 0, 0);
        idle(3);
        step(1, 0, 0, 0, 0, 0, 1, 0);
        idle(1);
        // R1: stalled strobe holds counter
        step(1, 1, 2, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
        idle(3);
        step(1, 0, 0, 0, 0, 0, 1, 0);
        // R1: load of 0 cancels, largest delay 3
        step(1, 1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0, 0);
        idle(2);
        step(1, 1, 3, 0, 0, 0, 0, 0);
        idle(4);
        step(1, 0, 0, 0, 0, 0, 1, 0);
        // R3: DMA lock over expiry cycles
        step(1, 1, 1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 1, 1, 0);
        step(1, 0, 0, 0, 0, 1, 1, 0);
        step(1, 0, 0, 0, 0, 0, 1, 0);
        step(1, 0, 0, 0, 0, 0, 1, 0);
        // R4, R5: IRQ sampling with mask and lock
        step(1, 0, 0, 4'b0010, 0, 0, 0, 0);
        step(1, 0, 0, 4'b0010, 0, 0, 1, 0);
        step(1, 0, 0, 4'b1100, 0, 1, 1, 0);
        step(1, 0, 0, 4'b1100, 1, 0, 1, 0);
        step(0, 0, 0, 4'b0000, 0, 0, 1, 0);
        idle(1);
        // R6: NMI and IRQ together, NMI first then IRQ
        step(1, 1, 1, 4'b0001, 0, 0, 0, 0);
        step(1, 0, 0, 4'b0001, 0, 0, 0, 0);
        step(1, 0, 0, 4'b0001, 0, 0, 1, 0);
        step(1, 0, 0, 4'b0001, 0, 0, 1, 0);
        idle(1);
        // R7, R8: halt woken by an IRQ, boundary ignored while halted
        step(1, 0, 0, 0, 0, 0, 0, 1);
        step(1, 0, 0, 0, 0, 0, 1, 0);
        step(1, 0, 0, 4'b1000, 0, 0, 1, 0);
        step(1, 0, 0, 4'b1000, 0, 0, 0, 0);
        idle(1);
        // R9: masked IRQ wakes without vectoring
        step(1, 0, 0, 0, 1, 0, 0, 1);
        step(1, 0, 0, 4'b0100, 1, 0, 0, 0);
        step(1, 0, 0, 4'b0000, 1, 0, 0, 0);
        idle(1);
        // R7: NMI wake, and a wake event in the entry cycle
        step(1, 1, 2, 0, 0, 0, 0, 1);
        idle(4);
        step(1, 0, 0, 4'b0001, 1, 0, 0, 1);
        idle(2);

        // mixed random traffic covering R1 to R10
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 8) != 0, ($urandom % 12) == 0, $urandom % 4,
                 (($urandom % 5) == 0) ? ($urandom % 16) : 0,
                 ($urandom % 3) == 0, ($urandom % 5) == 0,
                 ($urandom % 3) == 0, ($urandom % 20) == 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule